// File: doc/BRIEF.md
# Slow-Clock Uptime Counter with Cross-Domain Snapshot

This block keeps a free-running cycle count in a slow, always-on clock domain and lets a host on a fast bus clock obtain a coherent copy of it. The count starts at zero when the slow-domain reset is released and advances on every slow-clock edge. Because the count changes in another clock domain, the host cannot sample it directly. Instead it writes a request bit in the control register. The request travels into the slow domain as a toggle, where the count is copied into a snapshot buffer. An acknowledge toggle travels back, and a ready flag is then set on the bus side.

Software polls the ready flag and then reads the snapshot as a low 32-bit word and a high word. It rebuilds the value as `(high << 32) | low`. The buffer can change only while the ready flag is clear, so a read taken while the flag is set never sees a half-updated value.

Register map: address 0 is control/status, address 1 is the low word, address 2 is the high word, and every other address reads as zero.

Top module: `slowtmr_snap`

## Requirements
- R1: The slow-domain count is 0 while `rst_slow` is high and grows by exactly one on every `clk_slow` rising edge after that. Successive snapshots therefore never decrease.
- R2: After reset, the ready flag (bit 0 at address 0) reads 0, and addresses 0, 1, 2 and 3 all read 0.
- R3: A bus write to address 0 with data bit 0 set starts a snapshot if none is in flight. The ready flag is clear from the next `clk_bus` edge.
- R4: The ready flag sets no later than four `clk_slow` periods plus four `clk_bus` cycles after the request. The captured value is at least the count seen just before the request plus 2, and at most the count when the flag is seen set minus 1.
- R5: While the ready flag stays set, the low and high words do not change.
- R6: Address 1 returns count bits 31:0 and address 2 returns count bits 47:32 in bits 15:0. Bits 31:16 of address 2 always read 0.
- R7: A request written while a snapshot is still in flight is ignored. Exactly one capture completes, and the flag then stays set with an unchanging value.
- R8: Writes to address 0 with bit 0 clear, and writes to any other address, change neither the ready flag nor the buffered value.
- R9: A read is registered. `bus_rdata` shows the addressed register one `clk_bus` cycle after `bus_rd`, keeps its value when `bus_rd` is low, and reads 0 at addresses other than 0, 1 and 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bus | input | 1 | Fast host bus clock |
| rst_bus | input | 1 | Synchronous active-high reset, bus domain |
| clk_slow | input | 1 | Slow low-power counting clock |
| rst_slow | input | 1 | Synchronous active-high reset, slow domain |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 32 | Write data; bit 0 at address 0 requests a snapshot |
| bus_rdata | output | 32 | Registered read data |

## Verification
The hardest case to reach from the ports is a second request that lands while the first one is still crossing the two synchronizers. If the design handled it wrongly, two toggles could cancel in flight, or a late second capture could rewrite the buffer after the flag is set. The stimulus places back-to-back request writes, then polls and re-reads the buffer well past the crossing delay. Random idle gaps move each request across every phase of the non-harmonic slow clock. The captured value is bounded by a bench model of the slow count.

// File: rtl/slowtmr_pkg.sv
package slowtmr_pkg;

    localparam int unsigned BUS_DW  = 32;
    localparam int unsigned BUS_AW  = 4;
    localparam int unsigned CNT_W   = 48;
    localparam int unsigned SYNC_N  = 2;
    localparam int unsigned EXT_W   = 2 * BUS_DW;

    typedef enum logic [BUS_AW-1:0] {
        REG_CTRL = 4'd0,
        REG_LO   = 4'd1,
        REG_HI   = 4'd2
    } reg_sel_e;

    localparam int unsigned CTRL_REQ_BIT = 0;

    typedef struct packed {
        logic              wr;
        logic              rd;
        logic [BUS_AW-1:0] addr;
        logic [BUS_DW-1:0] wdata;
    } bus_req_t;

    // select one bus-wide word out of a zero-extended count
    function automatic logic [BUS_DW-1:0] word_of(input logic [EXT_W-1:0] v,
                                                  input logic upper);
        return upper ? v[EXT_W-1:BUS_DW] : v[BUS_DW-1:0];
    endfunction

endpackage

// File: rtl/slowtmr_tsync.sv
module slowtmr_tsync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] pipe;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) pipe <= '0;
                else     pipe <= d;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) pipe <= '0;
                else     pipe <= {pipe[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/slowtmr_slow_core.sv
module slowtmr_slow_core #(
    parameter int unsigned CNT_W  = slowtmr_pkg::CNT_W,
    parameter int unsigned SYNC_N = slowtmr_pkg::SYNC_N
) (
    input  logic             clk_slow,
    input  logic             rst_slow,
    input  logic             req_tgl_in,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] snap,
    output logic             ack_tgl
);
    logic req_s;
    logic req_seen;
    logic capture;

    slowtmr_tsync #(.STAGES(SYNC_N)) u_req_sync (
        .clk (clk_slow),
        .rst (rst_slow),
        .d   (req_tgl_in),
        .q   (req_s)
    );

    assign capture = req_s ^ req_seen;

    always_ff @(posedge clk_slow) begin
        if (rst_slow) begin
            count    <= '0;
            snap     <= '0;
            ack_tgl  <= 1'b0;
            req_seen <= 1'b0;
        end else begin
            count    <= count + CNT_W'(1);
            req_seen <= req_s;
            if (capture) begin
                snap    <= count;
                ack_tgl <= ~ack_tgl;
            end
        end
    end
endmodule

// File: rtl/slowtmr_bus_regs.sv
module slowtmr_bus_regs
    import slowtmr_pkg::*;
#(
    parameter int unsigned CNT_W  = slowtmr_pkg::CNT_W,
    parameter int unsigned SYNC_N = slowtmr_pkg::SYNC_N
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_req_t          breq,
    input  logic              ack_tgl_in,
    input  logic [CNT_W-1:0]  snap,
    output logic [BUS_DW-1:0] rdata,
    output logic              req_tgl,
    output logic              valid,
    output logic              pending
);
    logic ack_s;
    logic ack_seen;
    logic ack_edge;
    logic req_fire;
    logic wdata_unused;
    logic [EXT_W-1:0] snap_ext;
    logic [BUS_DW-1:0] rd_mux;

    slowtmr_tsync #(.STAGES(SYNC_N)) u_ack_sync (
        .clk (clk),
        .rst (rst),
        .d   (ack_tgl_in),
        .q   (ack_s)
    );

    assign wdata_unused = ^breq.wdata[BUS_DW-1:1];
    assign ack_edge     = ack_s ^ ack_seen;
    assign req_fire     = breq.wr && (breq.addr == REG_CTRL)
                          && breq.wdata[CTRL_REQ_BIT] && !pending;
    assign snap_ext     = EXT_W'(snap);

    always_ff @(posedge clk) begin
        if (rst) begin
            req_tgl  <= 1'b0;
            valid    <= 1'b0;
            pending  <= 1'b0;
            ack_seen <= 1'b0;
        end else begin
            ack_seen <= ack_s;
            if (req_fire) begin
                req_tgl <= ~req_tgl;
                pending <= 1'b1;
                valid   <= 1'b0;
            end else if (ack_edge) begin
                pending <= 1'b0;
                valid   <= 1'b1;
            end
        end
    end

    always_comb begin
        case (breq.addr)
            REG_CTRL: rd_mux = BUS_DW'(valid);
            REG_LO:   rd_mux = word_of(snap_ext, 1'b0);
            REG_HI:   rd_mux = word_of(snap_ext, 1'b1);
            default:  rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)          rdata <= '0;
        else if (breq.rd) rdata <= rd_mux;
    end
endmodule

// File: rtl/slowtmr_snap.sv
module slowtmr_snap
    import slowtmr_pkg::*;
#(
    parameter int unsigned CNT_W  = slowtmr_pkg::CNT_W,
    parameter int unsigned SYNC_N = slowtmr_pkg::SYNC_N
) (
    input  logic              clk_bus,
    input  logic              rst_bus,
    input  logic              clk_slow,
    input  logic              rst_slow,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic [BUS_DW-1:0] bus_wdata,
    output logic [BUS_DW-1:0] bus_rdata
);
    bus_req_t         breq;
    logic             req_tgl;
    logic             ack_tgl;
    logic             snap_valid;
    logic             snap_pending;
    logic [CNT_W-1:0] count;
    logic [CNT_W-1:0] snap;

    assign breq = '{wr: bus_wr, rd: bus_rd, addr: bus_addr, wdata: bus_wdata};

    slowtmr_slow_core #(.CNT_W(CNT_W), .SYNC_N(SYNC_N)) u_core (
        .clk_slow   (clk_slow),
        .rst_slow   (rst_slow),
        .req_tgl_in (req_tgl),
        .count      (count),
        .snap       (snap),
        .ack_tgl    (ack_tgl)
    );

    slowtmr_bus_regs #(.CNT_W(CNT_W), .SYNC_N(SYNC_N)) u_regs (
        .clk        (clk_bus),
        .rst        (rst_bus),
        .breq       (breq),
        .ack_tgl_in (ack_tgl),
        .snap       (snap),
        .rdata      (bus_rdata),
        .req_tgl    (req_tgl),
        .valid      (snap_valid),
        .pending    (snap_pending)
    );
endmodule

// File: rtl/slowtmr_snap_chk.sv
module slowtmr_snap_chk
    import slowtmr_pkg::*;
#(
    parameter int unsigned CNT_W = slowtmr_pkg::CNT_W
) (
    input logic              clk_bus,
    input logic              rst_bus,
    input logic              clk_slow,
    input logic              rst_slow,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [BUS_AW-1:0] bus_addr,
    input logic              req_bit,
    input logic [BUS_DW-1:0] bus_rdata,
    input logic              valid,
    input logic              pending,
    input logic [CNT_W-1:0]  snap,
    input logic [CNT_W-1:0]  count
);
    localparam int unsigned HI_W = CNT_W - BUS_DW;

    p_count_step_r1: assert property (@(posedge clk_slow) disable iff (rst_slow)
        !$past(rst_slow) |-> count == $past(count) + CNT_W'(1));

    p_req_clears_valid_r3: assert property (@(posedge clk_bus) disable iff (rst_bus)
        (bus_wr && bus_addr == REG_CTRL && req_bit) |=> !valid);

    p_valid_not_pending_r4: assert property (@(posedge clk_bus) disable iff (rst_bus)
        valid |-> !pending);

    p_no_tear_r5: assert property (@(posedge clk_bus) disable iff (rst_bus)
        (valid && $past(valid)) |-> $stable(snap));

    p_hi_zero_r6: assert property (@(posedge clk_bus) disable iff (rst_bus)
        (bus_rd && bus_addr == REG_HI) |=> bus_rdata[BUS_DW-1:HI_W] == '0);

    p_ctrl_read_r9: assert property (@(posedge clk_bus) disable iff (rst_bus)
        (bus_rd && bus_addr == REG_CTRL) |=> bus_rdata == BUS_DW'($past(valid)));
endmodule

bind slowtmr_snap slowtmr_snap_chk #(.CNT_W(CNT_W)) u_chk (
    .clk_bus   (clk_bus),
    .rst_bus   (rst_bus),
    .clk_slow  (clk_slow),
    .rst_slow  (rst_slow),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .req_bit   (bus_wdata[0]),
    .bus_rdata (bus_rdata),
    .valid     (snap_valid),
    .pending   (snap_pending),
    .snap      (snap),
    .count     (count)
);

// File: tb/slowtmr_snap_tb.sv
module slowtmr_snap_tb;
    logic        clk_bus = 1'b0;
    logic        clk_slow = 1'b0;
    logic        rst_bus = 1'b1;
    logic        rst_slow = 1'b1;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [3:0]  bus_addr = 4'd0;
    logic [31:0] bus_wdata = 32'd0;
    logic [31:0] bus_rdata;

    int     checks = 0;
    int     errors = 0;
    longint m = 0;          // bench model of the slow count

    always #2  clk_bus  = ~clk_bus;   // 250 MHz
    always #17 clk_slow = ~clk_slow;  // edges at odd ns, never on bus edges

    always @(posedge clk_slow) begin
        if (rst_slow) m <= 0;
        else          m <= m + 1;
    end

    slowtmr_snap u_dut (
        .clk_bus   (clk_bus),
        .rst_bus   (rst_bus),
        .clk_slow  (clk_slow),
        .rst_slow  (rst_slow),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk_bus);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk_bus);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk_bus);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk_bus);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    function automatic bit in_bounds(longint v, longint lo, longint hi);
        return (v >= lo) && (v <= hi);
    endfunction

    // request, poll for ready, read both words and check them
    task automatic take_snap(input bit double_req, output longint val);
        logic [31:0] d, lo, hi;
        longint mreq, mval;
        int lat;
        @(negedge clk_bus);
        mreq = m;
        bus_wr = 1'b1; bus_addr = 4'd0; bus_wdata = 32'd1;
        @(negedge clk_bus);
        if (double_req) begin
            @(negedge clk_bus);   // second request lands while in flight (R7)
        end
        bus_wr = 1'b0;
        bus_read(4'd0, d);
        chk(d[0] == 1'b0, "R3 ready clear after request", longint'(d[0]), 0);
        lat = 1;
        while (!d[0] && lat < 40) begin
            bus_read(4'd0, d);
            lat++;
        end
        mval = m;
        chk(d[0] == 1'b1, "R4 ready within latency bound", lat, 40);
        bus_read(4'd1, lo);
        bus_read(4'd2, hi);
        val = {hi, lo};
        chk(in_bounds(val, mreq + 2, mval - 1), "R4 captured value in window", val, mreq + 2);
        chk(hi[31:16] == 16'd0, "R6 high word upper bits zero", longint'(hi[31:16]), 0);
    endtask

    initial begin
        logic [31:0] d, lo0, lo1;
        longint v, prev;
        void'($urandom(32'h5EED_0042));

        repeat (10) @(negedge clk_bus);
        rst_bus = 1'b0;
        rst_slow = 1'b0;

        // R2: reset state
        for (int a = 0; a < 4; a++) begin
            bus_read(4'(a), d);
            chk(d == 32'd0, "R2 register reads zero after reset", longint'(d), 0);
        end

        // basic snapshot
        take_snap(1'b0, prev);

        // R5: stable while ready stays set
        bus_read(4'd1, lo0);
        repeat (50) @(negedge clk_bus);
        bus_read(4'd1, lo1);
        chk(lo0 == lo1, "R5 low word stable while ready", longint'(lo1), longint'(lo0));
        chk(lo0 == prev[31:0], "R6 low word equals captured bits", longint'(lo0), prev & 64'hFFFF_FFFF);

        // R8: ignored writes
        bus_write(4'd0, 32'hFFFF_FFFE);
        bus_write(4'd1, 32'hDEAD_BEEF);
        bus_write(4'd2, 32'h1234_5678);
        bus_write(4'd7, 32'hFFFF_FFFF);
        repeat (40) @(negedge clk_bus);
        bus_read(4'd0, d);
        chk(d == 32'd1, "R8 ready unchanged by ignored writes", longint'(d), 1);
        bus_read(4'd1, lo1);
        chk(lo1 == lo0, "R8 buffer unchanged by ignored writes", longint'(lo1), longint'(lo0));

        // R9: unmapped addresses, and hold when not reading
        for (int a = 3; a < 16; a++) begin
            bus_read(4'(a), d);
            chk(d == 32'd0, "R9 unmapped address reads zero", longint'(d), 0);
        end
        bus_read(4'd0, d);
        repeat (5) @(negedge clk_bus);
        chk(bus_rdata == 32'd1, "R9 read data held without strobe", longint'(bus_rdata), 1);

        // R7: back-to-back request while in flight
        take_snap(1'b1, v);
        chk(v > prev, "R1 count advances between snapshots", v, prev + 1);
        prev = v;
        repeat (120) @(negedge clk_bus);
        bus_read(4'd0, d);
        chk(d == 32'd1, "R7 ready stays set after double request", longint'(d), 1);
        bus_read(4'd1, lo1);
        chk(lo1 == prev[31:0], "R7 single capture, value unchanged", longint'(lo1), prev & 64'hFFFF_FFFF);

        // random gaps and interleaved ignored writes
        for (int i = 0; i < 30; i++) begin
            int gap;
            gap = $urandom_range(0, 80);
            repeat (gap) @(negedge clk_bus);
            if ($urandom_range(0, 1) == 1)
                bus_write(4'($urandom_range(1, 15)), $urandom);
            take_snap($urandom_range(0, 3) == 0, v);
            chk(v > prev, "R1 count advances between snapshots", v, prev + 1);
            prev = v;
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 4);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule